// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor

This block gathers interrupt requests and hands each of up to four processors the most urgent request aimed at it. Requests arrive in two ways. Peripheral wires drive the shared lines, which are 32 and up. Software can also raise a line through the register port. For every line the block keeps an enable flag, a pending flag, an active flag, an 8-bit priority, a set of target processors and a trigger mode. Lines 0 to 31 are private: each processor has its own copy of their enable, pending and active flags.

Software reaches the block through a plain 32-bit read/write port. A side input names the processor making each access. Each processor has its own forwarding output, which presents a valid flag, a line ID and that line's priority. The processor's interface answers on two strobes. An acknowledge strobe takes the forwarded line and makes it active. An end-of-interrupt strobe with an ID releases that line again. A software-interrupt register raises one of lines 0 to 15 on any chosen group of processors in a single write.

Top module: `dist_top`

## Requirements
- R1: After reset every enable, pending, active, priority, target, trigger and control bit is zero, and every `fwd_valid` output is low.
- R2: Line n's enable flag is bit n%32 of the word at 0x100+4*(n/32). Writing 1 there sets the flag. Writing 1 to the same bit at 0x180+4*(n/32) clears it. Writing 0 to either alias leaves the flag unchanged. Both aliases read back the current enable flags.
- R3: Pending flags use the same bit layout, with 0x200 as the set alias and 0x280 as the clear alias. Both aliases read back the current pending flags.
- R4: Line n's priority is byte n%4 of the word at 0x400+4*(n/4). Its target set is byte n%4 of the word at 0x800+4*(n/4), where bit c of the byte selects processor c. For lines 0 to 31 the target byte always reads as the requesting processor's own bit, and writes to it are ignored.
- R5: For a shared line n, bit 2*(n%16)+1 of the word at 0xC00+4*(n/16) selects rising-edge triggering when 1 and level triggering when 0. Every other bit in that region reads 0, and so does every bit belonging to lines 0 to 31.
- R6: Accesses to the enable, pending and active words of lines 0 to 31 reach only the copy that belongs to the processor named on `bus_cpu`.
- R7: A write to 0xF00 sets the pending flag of line wdata[3:0] in the private copy of each processor c for which wdata[16+c] is 1. The register reads as 0.
- R8: Bit 0 of 0x000 enables forwarding. While it is 0, no `fwd_valid` output is ever high.
- R9: For each processor the block forwards one line. The candidates are lines that are enabled, pending and not active, and, for shared lines, that target that processor. Among them the lowest priority value wins, and on equal values the lowest ID wins. `fwd_prio` carries the winner's priority byte.
- R10: Each input is sampled into a register. A level line is set pending on every cycle its sampled input is high. An edge line is set pending only when its sampled input rises. Either way the flag becomes visible two clock edges after the input changes.
- R11: An acknowledge strobe while `fwd_valid` is high clears the forwarded line's pending flag and sets its active flag. An end-of-interrupt strobe clears the active flag of the given ID. The active flags read at 0x300+4*(n/32), in the same layout as enable.
- R12: Reserved addresses, words beyond the implemented lines, and the active words all read back without taking any effect from a write. Reserved addresses and words beyond the implemented lines read as 0.
- R13: The word at 0x004 reads NUM_LINES/32-1 in bits [4:0] and NUM_CPUS-1 in bits [7:5].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | 2 | Index of the processor making the access |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_in | input | 32 | Peripheral requests for lines 32 and up |
| ack_in | input | 4 | Per-processor acknowledge strobe |
| eoi_in | input | 4 | Per-processor end-of-interrupt strobe |
| eoi_id_in | input | 24 | Per-processor ID being completed, 6 bits each |
| fwd_valid | output | 4 | Per-processor request present |
| fwd_id | output | 24 | Per-processor forwarded ID, 6 bits each |
| fwd_prio | output | 32 | Per-processor forwarded priority, 8 bits each |

## Verification
The randomised rounds draw priorities from only four values, so ties occur often. A selector that breaks ties toward the higher ID, or that ignores the target bits, then shows a wrong ID or priority on some processor. Directed cases write 0 to the set and clear aliases to catch a design that stores the written word instead of merging it. They read the private words from two processors to catch a missing bank, and they clear a pending flag while the input is still high to catch a design that confuses the edge and level modes. A further case checks that an acknowledged line stops being forwarded until its end-of-interrupt arrives, which a design that forgot to set the active flag would fail.

// File: rtl/dist_pkg.sv
package dist_pkg;
    localparam int BANK_LINES = 32;
    localparam int PRIO_W     = 8;

    typedef enum logic [3:0] {
        RG_NONE, RG_CTRL, RG_TYPE, RG_ENS, RG_ENC, RG_PNS,
        RG_PNC, RG_ACT, RG_PRI, RG_TGT, RG_CFG, RG_SGI
    } dist_reg_e;

    function automatic dist_reg_e dist_decode(input logic [11:0] a);
        if (a[1:0] != 2'b00)       return RG_NONE;
        if (a == 12'h000)          return RG_CTRL;
        if (a == 12'h004)          return RG_TYPE;
        if (a == 12'hF00)          return RG_SGI;
        case (a[11:7])
            5'h02:   return RG_ENS;
            5'h03:   return RG_ENC;
            5'h04:   return RG_PNS;
            5'h05:   return RG_PNC;
            5'h06:   return RG_ACT;
            default: ;
        endcase
        if (a[11:10] == 2'b01)     return RG_PRI;
        if (a[11:10] == 2'b10)     return RG_TGT;
        if (a[11:8] == 4'hC)       return RG_CFG;
        return RG_NONE;
    endfunction
endpackage

// File: rtl/dist_sync.sv
module dist_sync #(
    parameter int NSH = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NSH-1:0] irq_in,
    input  logic [NSH-1:0] edge_cfg,
    output logic [NSH-1:0] hit
);
    logic [NSH-1:0] smp_q, smp_d_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q   <= '0;
            smp_d_q <= '0;
        end else begin
            smp_q   <= irq_in;
            smp_d_q <= smp_q;
        end
    end

    // Level lines follow the sample; edge lines fire on a rise of the sample
    assign hit = (edge_cfg & smp_q & ~smp_d_q) | (~edge_cfg & smp_q);
endmodule

// File: rtl/dist_select.sv
module dist_select #(
    parameter int NUM_LINES = 64,
    parameter int ID_W      = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]      cand,
    input  logic [NUM_LINES-1:0][7:0] prio,
    output logic                      sel_v,
    output logic [ID_W-1:0]           sel_id,
    output logic [7:0]                sel_pr
);
    always_comb begin
        sel_v  = 1'b0;
        sel_id = '0;
        sel_pr = '1;
        // Ascending scan with strict compare keeps the lowest ID on ties
        for (int n = 0; n < NUM_LINES; n++) begin
            if (cand[n] && (!sel_v || prio[n] < sel_pr)) begin
                sel_v  = 1'b1;
                sel_id = ID_W'(n);
                sel_pr = prio[n];
            end
        end
    end
endmodule

// File: rtl/dist_regs.sv
module dist_regs
    import dist_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 4,
    parameter int NSH       = NUM_LINES - BANK_LINES,
    parameter int ID_W      = $clog2(NUM_LINES),
    parameter int CPU_W     = $clog2(NUM_CPUS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bus_sel,
    input  logic                                bus_wr,
    input  logic [CPU_W-1:0]                    bus_cpu,
    input  logic [11:0]                         bus_addr,
    input  logic [31:0]                         bus_wdata,
    output logic [31:0]                         bus_rdata,
    input  logic [NSH-1:0]                      hw_set,
    input  logic [NUM_CPUS-1:0]                 ack,
    input  logic [NUM_CPUS-1:0][ID_W-1:0]       ack_id,
    input  logic [NUM_CPUS-1:0]                 eoi,
    input  logic [NUM_CPUS-1:0][ID_W-1:0]       eoi_id,
    output logic                                ctl_q,
    output logic [NUM_CPUS-1:0][31:0]           pe_q,
    output logic [NUM_CPUS-1:0][31:0]           pp_q,
    output logic [NUM_CPUS-1:0][31:0]           pa_q,
    output logic [NSH-1:0]                      se_q,
    output logic [NSH-1:0]                      sp_q,
    output logic [NSH-1:0]                      sa_q,
    output logic [NUM_LINES-1:0][7:0]           pr_q,
    output logic [NSH-1:0][NUM_CPUS-1:0]        tg_q,
    output logic [NSH-1:0]                      ed_q
);
    dist_reg_e rg;
    int wi, bi, ci;
    logic ctl_n;
    logic [NUM_CPUS-1:0][31:0]    pe_n, pp_n, pa_n;
    logic [NSH-1:0]               se_n, sp_n, sa_n, ed_n;
    logic [NUM_LINES-1:0][7:0]    pr_n;
    logic [NSH-1:0][NUM_CPUS-1:0] tg_n;

    assign rg = dist_decode(bus_addr);
    assign wi = int'(bus_addr[6:2]);
    assign bi = int'(bus_addr[9:2]);
    assign ci = int'(bus_addr[7:2]);

    // Next state: hardware sets, then bus writes, then end-of-interrupt, then acknowledge
    always_comb begin
        ctl_n = ctl_q;
        pe_n = pe_q; pp_n = pp_q; pa_n = pa_q;
        se_n = se_q; sa_n = sa_q; ed_n = ed_q;
        pr_n = pr_q; tg_n = tg_q;
        sp_n = sp_q | hw_set;
        if (bus_sel && bus_wr) begin
            case (rg)
                RG_CTRL: ctl_n = bus_wdata[0];
                RG_ENS, RG_ENC, RG_PNS, RG_PNC: begin
                    if (wi == 0) begin
                        case (rg)
                            RG_ENS:  pe_n[bus_cpu] = pe_q[bus_cpu] | bus_wdata;
                            RG_ENC:  pe_n[bus_cpu] = pe_q[bus_cpu] & ~bus_wdata;
                            RG_PNS:  pp_n[bus_cpu] = pp_q[bus_cpu] | bus_wdata;
                            default: pp_n[bus_cpu] = pp_q[bus_cpu] & ~bus_wdata;
                        endcase
                    end
                    for (int i = 0; i < NSH; i++) begin
                        if ((i + BANK_LINES) / 32 == wi && bus_wdata[i % 32]) begin
                            case (rg)
                                RG_ENS:  se_n[i] = 1'b1;
                                RG_ENC:  se_n[i] = 1'b0;
                                RG_PNS:  sp_n[i] = 1'b1;
                                default: sp_n[i] = 1'b0;
                            endcase
                        end
                    end
                end
                RG_PRI: begin
                    for (int n = 0; n < NUM_LINES; n++)
                        if (n / 4 == bi) pr_n[n] = bus_wdata[8*(n%4) +: 8];
                end
                RG_TGT: begin
                    for (int i = 0; i < NSH; i++)
                        if ((i + BANK_LINES) / 4 == bi)
                            tg_n[i] = bus_wdata[8*(i%4) +: NUM_CPUS];
                end
                RG_CFG: begin
                    for (int i = 0; i < NSH; i++)
                        if ((i + BANK_LINES) / 16 == ci)
                            ed_n[i] = bus_wdata[2*(i%16) + 1];
                end
                RG_SGI: begin
                    for (int c = 0; c < NUM_CPUS; c++)
                        if (bus_wdata[16 + c]) pp_n[c][bus_wdata[3:0]] = 1'b1;
                end
                default: ;
            endcase
        end
        for (int c = 0; c < NUM_CPUS; c++) begin
            if (eoi[c]) begin
                for (int b = 0; b < BANK_LINES; b++)
                    if (eoi_id[c] == ID_W'(b)) pa_n[c][b] = 1'b0;
                for (int i = 0; i < NSH; i++)
                    if (eoi_id[c] == ID_W'(i + BANK_LINES)) sa_n[i] = 1'b0;
            end
        end
        for (int c = 0; c < NUM_CPUS; c++) begin
            if (ack[c]) begin
                for (int b = 0; b < BANK_LINES; b++)
                    if (ack_id[c] == ID_W'(b)) begin
                        pp_n[c][b] = 1'b0;
                        pa_n[c][b] = 1'b1;
                    end
                for (int i = 0; i < NSH; i++)
                    if (ack_id[c] == ID_W'(i + BANK_LINES)) begin
                        sp_n[i] = 1'b0;
                        sa_n[i] = 1'b1;
                    end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= 1'b0;
            pe_q <= '0; pp_q <= '0; pa_q <= '0;
            se_q <= '0; sp_q <= '0; sa_q <= '0; ed_q <= '0;
            pr_q <= '0; tg_q <= '0;
        end else begin
            ctl_q <= ctl_n;
            pe_q <= pe_n; pp_q <= pp_n; pa_q <= pa_n;
            se_q <= se_n; sp_q <= sp_n; sa_q <= sa_n; ed_q <= ed_n;
            pr_q <= pr_n; tg_q <= tg_n;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (rg)
            RG_CTRL: bus_rdata[0] = ctl_q;
            RG_TYPE: begin
                bus_rdata[4:0] = 5'(NUM_LINES / 32 - 1);
                bus_rdata[7:5] = 3'(NUM_CPUS - 1);
            end
            RG_ENS, RG_ENC, RG_PNS, RG_PNC, RG_ACT: begin
                if (wi == 0) begin
                    case (rg)
                        RG_ENS, RG_ENC: bus_rdata = pe_q[bus_cpu];
                        RG_PNS, RG_PNC: bus_rdata = pp_q[bus_cpu];
                        default:        bus_rdata = pa_q[bus_cpu];
                    endcase
                end
                for (int i = 0; i < NSH; i++) begin
                    if ((i + BANK_LINES) / 32 == wi) begin
                        case (rg)
                            RG_ENS, RG_ENC: bus_rdata[i % 32] = se_q[i];
                            RG_PNS, RG_PNC: bus_rdata[i % 32] = sp_q[i];
                            default:        bus_rdata[i % 32] = sa_q[i];
                        endcase
                    end
                end
            end
            RG_PRI: begin
                for (int n = 0; n < NUM_LINES; n++)
                    if (n / 4 == bi) bus_rdata[8*(n%4) +: 8] = pr_q[n];
            end
            RG_TGT: begin
                for (int n = 0; n < BANK_LINES; n++)
                    if (n / 4 == bi) bus_rdata[8*(n%4) + int'(bus_cpu)] = 1'b1;
                for (int i = 0; i < NSH; i++)
                    if ((i + BANK_LINES) / 4 == bi) bus_rdata[8*(i%4) +: NUM_CPUS] = tg_q[i];
            end
            RG_CFG: begin
                for (int i = 0; i < NSH; i++)
                    if ((i + BANK_LINES) / 16 == ci) bus_rdata[2*(i%16) + 1] = ed_q[i];
            end
            default: ;
        endcase
    end

    // R2
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && (rg == RG_ENS || rg == RG_ENC)) |=> $stable(se_q) && $stable(pe_q));

    // R12
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (rg == RG_NONE || rg == RG_SGI)) |-> bus_rdata == 32'h0);
endmodule

// File: rtl/dist_top.sv
module dist_top
    import dist_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   bus_sel,
    input  logic                                   bus_wr,
    input  logic [$clog2(NUM_CPUS)-1:0]            bus_cpu,
    input  logic [11:0]                            bus_addr,
    input  logic [31:0]                            bus_wdata,
    output logic [31:0]                            bus_rdata,
    input  logic [NUM_LINES-33:0]                  irq_in,
    input  logic [NUM_CPUS-1:0]                    ack_in,
    input  logic [NUM_CPUS-1:0]                    eoi_in,
    input  logic [NUM_CPUS*$clog2(NUM_LINES)-1:0]  eoi_id_in,
    output logic [NUM_CPUS-1:0]                    fwd_valid,
    output logic [NUM_CPUS*$clog2(NUM_LINES)-1:0]  fwd_id,
    output logic [NUM_CPUS*8-1:0]                  fwd_prio
);
    localparam int NSH   = NUM_LINES - BANK_LINES;
    localparam int ID_W  = $clog2(NUM_LINES);
    localparam int CPU_W = $clog2(NUM_CPUS);

    logic                           ctl_en;
    logic [NUM_CPUS-1:0][31:0]      pe, pp, pa;
    logic [NSH-1:0]                 se, sp, sa, ed, hit;
    logic [NUM_LINES-1:0][7:0]      pr;
    logic [NSH-1:0][NUM_CPUS-1:0]   tg;
    logic [NUM_CPUS-1:0]            sel_v, ack_ok;
    logic [NUM_CPUS-1:0][ID_W-1:0]  sel_id, eoi_pk;
    logic [NUM_CPUS-1:0][7:0]       sel_pr;
    logic [NUM_CPUS-1:0][NUM_LINES-1:0] cand, act_vec;
    logic [NUM_CPUS-1:0][NSH-1:0]   tcol;

    assign fwd_valid = sel_v & {NUM_CPUS{ctl_en}};
    assign ack_ok    = ack_in & fwd_valid;

    dist_sync #(.NSH(NSH)) u_sync (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .edge_cfg(ed), .hit(hit)
    );

    dist_regs #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .NSH(NSH), .ID_W(ID_W), .CPU_W(CPU_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_cpu(bus_cpu),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_set(hit),
        .ack(ack_ok), .ack_id(sel_id), .eoi(eoi_in), .eoi_id(eoi_pk),
        .ctl_q(ctl_en), .pe_q(pe), .pp_q(pp), .pa_q(pa), .se_q(se), .sp_q(sp), .sa_q(sa),
        .pr_q(pr), .tg_q(tg), .ed_q(ed)
    );

    always_comb begin
        for (int c = 0; c < NUM_CPUS; c++) begin
            for (int i = 0; i < NSH; i++) tcol[c][i] = tg[i][c];
            cand[c]    = {se & sp & ~sa & tcol[c], pe[c] & pp[c] & ~pa[c]};
            act_vec[c] = {sa, pa[c]};
        end
    end

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        assign eoi_pk[c] = eoi_id_in[c*ID_W +: ID_W];

        dist_select #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_sel (
            .cand(cand[c]), .prio(pr), .sel_v(sel_v[c]), .sel_id(sel_id[c]), .sel_pr(sel_pr[c])
        );

        assign fwd_id[c*ID_W +: ID_W] = sel_id[c];
        assign fwd_prio[c*8 +: 8]     = sel_pr[c];

        // R9
        fwd_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fwd_valid[c] |-> cand[c][sel_id[c]] && sel_pr[c] == pr[sel_id[c]]);

        // R11
        ack_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_ok[c] && eoi_in == '0) |=> act_vec[c][$past(sel_id[c])]);
    end

    // R8
    fwd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> fwd_valid == '0);
endmodule

// File: tb/dist_top_test.sv
module dist_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 64;
    localparam int NC = 4;
    localparam int IW = 6;

    logic clk = 0, rst_n = 0;
    logic bus_sel = 0, bus_wr = 0;
    logic [1:0] bus_cpu = 0;
    logic [11:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [31:0] irq_in = 0;
    logic [NC-1:0] ack_in = 0, eoi_in = 0;
    logic [NC*IW-1:0] eoi_id_in = 0;
    logic [NC-1:0] fwd_valid;
    logic [NC*IW-1:0] fwd_id;
    logic [NC*8-1:0] fwd_prio;

    int nchk = 0, nerr = 0;
    logic [31:0] rv;
    int sh_pr[64];
    bit [3:0] sh_tg[64];
    bit sh_en[64], sh_pd[64];

    always #(CLK_PERIOD/2) clk = ~clk;

    dist_top #(.NUM_LINES(NL), .NUM_CPUS(NC)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_cpu(bus_cpu),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .ack_in(ack_in), .eoi_in(eoi_in), .eoi_id_in(eoi_id_in),
        .fwd_valid(fwd_valid), .fwd_id(fwd_id), .fwd_prio(fwd_prio)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] c = 0);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_cpu = c;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [1:0] c, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a; bus_cpu = c;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic strobe_ack(input int c);
        @(negedge clk); ack_in[c] = 1;
        @(negedge clk); ack_in[c] = 0;
    endtask

    task automatic strobe_eoi(input int c, input logic [IW-1:0] id);
        @(negedge clk); eoi_in[c] = 1; eoi_id_in[c*IW +: IW] = id;
        @(negedge clk); eoi_in[c] = 0;
    endtask

    // Expected winner for one CPU over the shared lines from the bench's own shadow
    function automatic logic [31:0] pick(input int c);
        int best = -1;
        for (int n = 32; n < 64; n++)
            if (sh_en[n] && sh_pd[n] && sh_tg[n][c] && (best < 0 || sh_pr[n] < sh_pr[best]))
                best = n;
        if (best < 0) return 32'h0;
        return {15'h0, 1'b1, 8'(sh_pr[best]), 2'b0, 6'(best)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got %h expected %h", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 / R13
        rd(12'h000, 0, rv); check("R1 ctrl", rv, 0);
        check("R1 fwd_valid", 32'(fwd_valid), 0);
        rd(12'h104, 0, rv); check("R1 enable", rv, 0);
        rd(12'h420, 0, rv); check("R1 priority", rv, 0);
        rd(12'h004, 0, rv); check("R13 type", rv, 32'h61);
        // R2
        wr(12'h104, 32'hF0); rd(12'h104, 0, rv); check("R2 set", rv, 32'hF0);
        wr(12'h184, 32'h30); rd(12'h184, 0, rv); check("R2 clear", rv, 32'hC0);
        wr(12'h104, 32'h0);  rd(12'h104, 0, rv); check("R2 zero to set", rv, 32'hC0);
        wr(12'h184, 32'h0);  rd(12'h104, 0, rv); check("R2 zero to clear", rv, 32'hC0);
        wr(12'h184, 32'hFFFF_FFFF);
        // R3
        wr(12'h204, 32'h0001_0001); wr(12'h284, 32'h1);
        rd(12'h204, 0, rv); check("R3 pending", rv, 32'h0001_0000);
        wr(12'h284, 32'hFFFF_FFFF);
        // R4
        wr(12'h420, 32'h4433_2211); rd(12'h420, 0, rv); check("R4 priority", rv, 32'h4433_2211);
        wr(12'h800, 32'hFFFF_FFFF, 2); rd(12'h800, 2, rv); check("R4 banked target", rv, 32'h0404_0404);
        wr(12'h820, 32'hFFFF_FF0F); rd(12'h820, 1, rv); check("R4 target", rv, 32'h0F0F_0F0F);
        // R5
        wr(12'hC08, 32'hFFFF_FFFF); rd(12'hC08, 0, rv); check("R5 config", rv, 32'hAAAA_AAAA);
        wr(12'hC04, 32'hFFFF_FFFF); rd(12'hC04, 0, rv); check("R5 banked config", rv, 0);
        wr(12'hC08, 32'h0);
        // R6
        wr(12'h100, 32'h1, 1);
        rd(12'h100, 0, rv); check("R6 other bank", rv, 0);
        rd(12'h100, 1, rv); check("R6 own bank", rv, 1);
        wr(12'h180, 32'h1, 1);
        // R7
        wr(12'hF00, 32'h0005_0005);
        rd(12'h200, 0, rv); check("R7 cpu0", rv, 32'h20);
        rd(12'h200, 1, rv); check("R7 cpu1", rv, 0);
        rd(12'h200, 2, rv); check("R7 cpu2", rv, 32'h20);
        rd(12'hF00, 0, rv); check("R7 readback", rv, 0);
        wr(12'h280, 32'hFFFF_FFFF, 2);
        // R8 / R9 / R11 : line 5 private to cpu0 (still pending), line 40 shared
        wr(12'h100, 32'h20);
        wr(12'h404, 32'h0000_8000);
        wr(12'h428, 32'h0000_0040);
        wr(12'h828, 32'h0000_0001);
        wr(12'h104, 32'h100);
        wr(12'h204, 32'h100);
        check("R8 off", 32'(fwd_valid), 0);
        wr(12'h000, 32'h1);
        check("R9 valid", 32'(fwd_valid), 32'h1);
        check("R9 id", 32'(fwd_id[5:0]), 40);
        check("R9 prio", 32'(fwd_prio[7:0]), 32'h40);
        strobe_ack(0);
        check("R11 next id", 32'(fwd_id[5:0]), 5);
        check("R11 next prio", 32'(fwd_prio[7:0]), 32'h80);
        rd(12'h304, 0, rv); check("R11 active", rv, 32'h100);
        rd(12'h204, 0, rv); check("R11 pending cleared", rv, 0);
        strobe_eoi(0, 6'd40);
        rd(12'h304, 0, rv); check("R11 eoi", rv, 0);
        // R12
        wr(12'h304, 32'hFFFF_FFFF); rd(12'h304, 0, rv); check("R12 active ro", rv, 0);
        wr(12'h108, 32'hFFFF_FFFF); rd(12'h108, 0, rv); check("R12 beyond lines", rv, 0);
        wr(12'h440, 32'hFFFF_FFFF); rd(12'h440, 0, rv); check("R12 beyond prio", rv, 0);
        wr(12'h050, 32'hFFFF_FFFF); rd(12'h050, 0, rv); check("R12 reserved", rv, 0);
        // R10 : line 50 edge, line 51 level
        wr(12'hC0C, 32'h20);
        @(negedge clk); irq_in[18] = 1; irq_in[19] = 1;
        @(negedge clk); @(negedge clk);
        rd(12'h204, 0, rv); check("R10 both set", rv & 32'h000C_0000, 32'h000C_0000);
        wr(12'h284, 32'h000C_0000);
        @(negedge clk); @(negedge clk);
        rd(12'h204, 0, rv); check("R10 level reasserts, edge stays clear", rv & 32'h000C_0000, 32'h0008_0000);
        @(negedge clk); irq_in = 0;
        @(negedge clk); @(negedge clk);
        wr(12'h284, 32'hFFFF_FFFF); wr(12'hC0C, 32'h0);
        wr(12'h180, 32'hFFFF_FFFF); wr(12'h280, 32'hFFFF_FFFF);
        // R9 random rounds with frequent priority ties
        for (int it = 0; it < 30; it++) begin
            logic [31:0] em, pm;
            wr(12'h184, 32'hFFFF_FFFF); wr(12'h284, 32'hFFFF_FFFF);
            for (int w = 8; w < 16; w++) begin
                logic [31:0] pw, tw;
                for (int b = 0; b < 4; b++) begin
                    sh_pr[4*w+b] = int'($urandom % 4) * 16;
                    sh_tg[4*w+b] = 4'($urandom);
                    pw[8*b +: 8] = 8'(sh_pr[4*w+b]);
                    tw[8*b +: 8] = {4'h0, sh_tg[4*w+b]};
                end
                wr(12'(12'h400 + 4*w), pw);
                wr(12'(12'h800 + 4*w), tw);
            end
            em = $urandom; pm = $urandom;
            for (int n = 32; n < 64; n++) begin
                sh_en[n] = em[n-32];
                sh_pd[n] = pm[n-32];
            end
            wr(12'h104, em); wr(12'h204, pm);
            for (int c = 0; c < NC; c++) begin
                logic [31:0] e;
                e = pick(c);
                check("R9 random pick", {15'h0, fwd_valid[c], (fwd_valid[c] ? fwd_prio[c*8 +: 8] : 8'h0),
                      2'b0, (fwd_valid[c] ? fwd_id[c*IW +: IW] : 6'h0)}, e);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule